// File: doc/BRIEF.md
# Opcode-to-Control Decoder

This block is the control unit of a small 16-bit single-cycle processor. It takes the 4-bit opcode nibble from the top of each instruction word and drives the control lines that steer the datapath: register-file write enable, choice of destination field, ALU second-operand source, ALU operation, data-memory write enable, write-back source, and the branch and jump flags. It holds no state. Every output follows the opcode with no clock, and a new opcode takes effect in the same cycle the instruction is presented.

Internally the opcode is first sorted into an instruction class (arithmetic, load, store, branch, jump, or none). For the arithmetic class, an ALU operation is also derived from the opcode. A second stage turns the class into a control word. The top module unpacks that word onto individual output lines. No state machine is present, because the decode is a pure function of the opcode.

Top module: `instr_ctrl_decoder`

## Requirements
- R1: Opcodes 0010, 0011, 0100 and 0101 each set `reg_wr_en`=1, `dest_is_rt`=0 (destination is bits 3:0), `opb_is_imm`=0, `wb_from_mem`=0, `mem_wr_en`=0, `is_branch`=0 and `is_jump`=0. For these four opcodes `alu_func` is 00, 01, 10 and 11 respectively (add, subtract, AND, OR).
- R2: Opcode 0000 (load word) sets `reg_wr_en`=1, `dest_is_rt`=1 (destination is bits 7:4), `opb_is_imm`=1, `alu_func`=00 (add) and `wb_from_mem`=1. It leaves `mem_wr_en`, `is_branch` and `is_jump` at 0.
- R3: Opcode 0001 (store word) sets `mem_wr_en`=1, `opb_is_imm`=1 and `alu_func`=00 (add). It leaves `reg_wr_en`, `dest_is_rt`, `wb_from_mem`, `is_branch` and `is_jump` at 0.
- R4: Opcode 0111 (branch if equal) sets `is_branch`=1 and `alu_func`=01 (subtract), so that the ALU zero flag can serve as the condition. Its operands come from registers (`opb_is_imm`=0), and every other output is 0.
- R5: Opcode 1000 (jump) sets `is_jump`=1, and every other output is 0, including `alu_func`=00.
- R6: Opcodes 0110 and 1001 through 1111 drive every output to 0.
- R7: For every opcode, at most one of `reg_wr_en`, `mem_wr_en`, `is_branch` and `is_jump` is 1.
- R8: `wb_from_mem`=1 only together with `reg_wr_en`=1 and `dest_is_rt`=1, and `opb_is_imm`=1 only for the load and store opcodes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Opcode nibble, bits 15:12 of the instruction |
| reg_wr_en | output | 1 | Register file write enable |
| dest_is_rt | output | 1 | 1: write register taken from bits 7:4; 0: from bits 3:0 |
| opb_is_imm | output | 1 | 1: ALU operand B is the sign-extended offset; 0: second register |
| alu_func | output | 2 | ALU operation: 00 add, 01 subtract, 10 AND, 11 OR |
| mem_wr_en | output | 1 | Data memory write enable |
| wb_from_mem | output | 1 | 1: write-back from memory read data; 0: from ALU result |
| is_branch | output | 1 | Conditional branch on ALU zero |
| is_jump | output | 1 | Unconditional jump |

## Verification
The bench targets the opcodes that sit next to defined ones: 0110 between the logical and branch opcodes, and 1001 just past jump. A decoder using too coarse a range check would give these opcodes a register write or a branch. Load and store are checked for the destination field and the write-back source. A decoder that mixed these up would write the wrong register, or write memory data on a store. A sweep of all sixteen opcodes checks every output and the exclusivity of the four action flags. This catches any single-entry swap in the table, such as branch wired to add or jump leaving an ALU operation set.

// File: rtl/idec_pkg.sv
package idec_pkg;
    localparam int OP_W    = 4;
    localparam int ALUOP_W = 2;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'b0000;
    localparam logic [OP_W-1:0] OPC_STORE = 4'b0001;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'b0010;
    localparam logic [OP_W-1:0] OPC_SUB   = 4'b0011;
    localparam logic [OP_W-1:0] OPC_AND   = 4'b0100;
    localparam logic [OP_W-1:0] OPC_OR    = 4'b0101;
    localparam logic [OP_W-1:0] OPC_BEQ   = 4'b0111;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'b1000;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_ARITH,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH,
        CLS_JUMP
    } cls_e;

    typedef enum logic [ALUOP_W-1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_AND = 2'b10,
        ALU_OR  = 2'b11
    } alu_e;

    typedef struct packed {
        logic reg_we;
        logic dst_rt;
        logic src_imm;
        alu_e alu_op;
        logic mem_we;
        logic wb_mem;
        logic branch;
        logic jump;
    } ctrl_t;
endpackage

// File: rtl/idec_classify.sv
module idec_classify
    import idec_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output cls_e            cls,
    output alu_e            arith_op
);
    always_comb begin
        unique case (opcode)
            OPC_LOAD:                       cls = CLS_LOAD;
            OPC_STORE:                      cls = CLS_STORE;
            OPC_ADD, OPC_SUB, OPC_AND, OPC_OR: cls = CLS_ARITH;
            OPC_BEQ:                        cls = CLS_BRANCH;
            OPC_JUMP:                       cls = CLS_JUMP;
            default:                        cls = CLS_NONE;
        endcase
    end

    // arithmetic opcodes are consecutive from OPC_ADD; offset gives the op
    always_comb begin
        arith_op = alu_e'(opcode[ALUOP_W-1:0] - OPC_ADD[ALUOP_W-1:0]);
    end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  cls_e  cls,
    input  alu_e  arith_op,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '0;
        unique case (cls)
            CLS_ARITH: begin
                ctrl.reg_we = 1'b1;
                ctrl.alu_op = arith_op;
            end
            CLS_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.dst_rt  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
                ctrl.wb_mem  = 1'b1;
            end
            CLS_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            CLS_BRANCH: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            CLS_JUMP: begin
                ctrl.jump = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/instr_ctrl_decoder.sv
module instr_ctrl_decoder
    import idec_pkg::*;
(
    input  logic [3:0] opcode,
    output logic       reg_wr_en,
    output logic       dest_is_rt,
    output logic       opb_is_imm,
    output logic [1:0] alu_func,
    output logic       mem_wr_en,
    output logic       wb_from_mem,
    output logic       is_branch,
    output logic       is_jump
);
    cls_e  cls;
    alu_e  arith_op;
    ctrl_t ctrl;

    idec_classify u_classify (
        .opcode   (opcode),
        .cls      (cls),
        .arith_op (arith_op)
    );

    idec_ctrl u_ctrl (
        .cls      (cls),
        .arith_op (arith_op),
        .ctrl     (ctrl)
    );

    always_comb begin
        reg_wr_en   = ctrl.reg_we;
        dest_is_rt  = ctrl.dst_rt;
        opb_is_imm  = ctrl.src_imm;
        alu_func    = ctrl.alu_op;
        mem_wr_en   = ctrl.mem_we;
        wb_from_mem = ctrl.wb_mem;
        is_branch   = ctrl.branch;
        is_jump     = ctrl.jump;
    end

    // checks against the opcode port, across both decode stages
    always_comb begin
        assert_action_excl_R7: assert ($countones({reg_wr_en, mem_wr_en, is_branch, is_jump}) <= 1)
            else $error("R7: more than one action flag");
        assert_wb_mem_load_R8: assert (!wb_from_mem || (reg_wr_en && dest_is_rt))
            else $error("R8: memory write-back without Rt write");
        assert_imm_mem_only_R8: assert (!opb_is_imm || (opcode == OPC_LOAD) || (opcode == OPC_STORE))
            else $error("R8: immediate operand on non-memory opcode");
        assert_store_no_reg_R3: assert (!(opcode == OPC_STORE) || (mem_wr_en && !reg_wr_en))
            else $error("R3: store decode wrong");
        assert_jump_alone_R5: assert (!is_jump || (alu_func == 2'b00 && !opb_is_imm && !dest_is_rt && !wb_from_mem))
            else $error("R5: jump drives other controls");
        assert_branch_sub_R4: assert (!is_branch || (alu_func == 2'b01 && !opb_is_imm))
            else $error("R4: branch without register subtract");
        assert_undef_idle_R6: assert (!(opcode == 4'b0110 || opcode >= 4'b1001)
                                      || {reg_wr_en, dest_is_rt, opb_is_imm, alu_func,
                                          mem_wr_en, wb_from_mem, is_branch, is_jump} == '0)
            else $error("R6: undefined opcode not idle");
    end
endmodule

// File: tb/instr_ctrl_decoder_test.sv
module instr_ctrl_decoder_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] opcode = 4'b0000;
    logic       reg_wr_en, dest_is_rt, opb_is_imm, mem_wr_en, wb_from_mem, is_branch, is_jump;
    logic [1:0] alu_func;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_ctrl_decoder uut (
        .opcode      (opcode),
        .reg_wr_en   (reg_wr_en),
        .dest_is_rt  (dest_is_rt),
        .opb_is_imm  (opb_is_imm),
        .alu_func    (alu_func),
        .mem_wr_en   (mem_wr_en),
        .wb_from_mem (wb_from_mem),
        .is_branch   (is_branch),
        .is_jump     (is_jump)
    );

    // packed {reg_we, dst_rt, imm, alu[1:0], mem_we, wb_mem, branch, jump}
    function automatic logic [8:0] expect_ctrl(input logic [3:0] op);
        case (op)
            4'b0010: return 9'b1_0_0_00_0_0_0_0;
            4'b0011: return 9'b1_0_0_01_0_0_0_0;
            4'b0100: return 9'b1_0_0_10_0_0_0_0;
            4'b0101: return 9'b1_0_0_11_0_0_0_0;
            4'b0000: return 9'b1_1_1_00_0_1_0_0;
            4'b0001: return 9'b0_0_1_00_1_0_0_0;
            4'b0111: return 9'b0_0_0_01_0_0_1_0;
            4'b1000: return 9'b0_0_0_00_0_0_0_1;
            default: return 9'b0;
        endcase
    endfunction

    function automatic logic [8:0] observed();
        return {reg_wr_en, dest_is_rt, opb_is_imm, alu_func, mem_wr_en, wb_from_mem, is_branch, is_jump};
    endfunction

    task automatic apply_and_check(input logic [3:0] op, input string req);
        @(negedge clk);
        opcode = op;
        #(CLK_PERIOD/4);
        total++;
        if (observed() !== expect_ctrl(op)) begin
            bad++;
            $display("FAIL %s opcode=%b got=%b expected=%b", req, op, observed(), expect_ctrl(op));
        end
    endtask

    task automatic test_arith;   // R1
        apply_and_check(4'b0010, "R1");
        apply_and_check(4'b0011, "R1");
        apply_and_check(4'b0100, "R1");
        apply_and_check(4'b0101, "R1");
    endtask

    task automatic test_load;    // R2
        apply_and_check(4'b0000, "R2");
    endtask

    task automatic test_store;   // R3
        apply_and_check(4'b0001, "R3");
    endtask

    task automatic test_branch;  // R4
        apply_and_check(4'b0111, "R4");
    endtask

    task automatic test_jump;    // R5
        apply_and_check(4'b1000, "R5");
    endtask

    task automatic test_undefined; // R6
        apply_and_check(4'b0110, "R6");
        for (int k = 9; k < 16; k++) apply_and_check(4'(k), "R6");
    endtask

    task automatic test_sweep;   // R7, R8
        for (int k = 0; k < 16; k++) begin
            apply_and_check(4'(k), "R7");
            total++;
            if ($countones({reg_wr_en, mem_wr_en, is_branch, is_jump}) > 1) begin
                bad++;
                $display("FAIL R7 opcode=%0d got=%b expected=at most one flag", k,
                         {reg_wr_en, mem_wr_en, is_branch, is_jump});
            end
            total++;
            if ((wb_from_mem && !(reg_wr_en && dest_is_rt)) || (opb_is_imm && k > 1)) begin
                bad++;
                $display("FAIL R8 opcode=%0d got=wb%b we%b rt%b imm%b expected=consistent", k,
                         wb_from_mem, reg_wr_en, dest_is_rt, opb_is_imm);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        bad++;
        total++;
        $display("FAIL watchdog got=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_load();       // initial opcode state, R2
        test_arith();
        test_store();
        test_branch();
        test_jump();
        test_undefined();
        test_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule